// File: doc/BRIEF.md
# Reset Cause Status Register

This block remembers why the system last came out of reset. Seven reset-cause inputs come from the reset generators: power-on, external reset pin, watchdog timeout, illegal opcode, illegal address on an opcode fetch, monitor-mode entry and low-voltage inhibit. The block samples these inputs on the clock edge at which the system reset is released. It then holds the result as a status byte that software reads over a simple register bus. The circuits that decide whether a fetch address is illegal, or whether both reset-vector bytes read as all ones, are outside this block. Each arrives here only as a cause input.

Reading the status byte clears the recorded causes. A second register holds a clear-enable bit for debug break. While a debug halt is active and that bit is 0, a status read returns the flags and leaves them in place, so a debugger can inspect the byte without destroying it. The register bus has no back-pressure. A read strobe returns data combinationally in the same cycle, and a write strobe takes effect at the next clock edge. Every access is accepted in the cycle it is presented.

The flag storage has no reset of its own. It is loaded by the capture on every release of the system reset, which keeps the previous cause readable until the new one replaces it.

Top module: `reset_cause_status`

## Requirements
- R1: When the power-on cause is high at reset release, the status byte is 0x80 (power-on flag in bit 7, all other bits 0), even if other causes are also high.
- R2: When power-on is low at reset release, each cause input maps to one status bit: pin to bit 6, watchdog to bit 5, illegal opcode to bit 4, illegal address to bit 3, monitor entry to bit 2 and low voltage to bit 1. Bit 0 reads 0. Flags from the previous reset are replaced, not accumulated.
- R3: When several non-power-on causes are high at the same release, all of their flags are set together.
- R4: A read strobe at the status address returns the flags in the same cycle. Outside debug break, the flags are 0 from the next clock edge on.
- R5: While `dbg_break` is high and the clear-enable bit is 0, a status read returns the flags and leaves them unchanged.
- R6: While `dbg_break` is high and the clear-enable bit is 1, a status read clears the flags, as in R4.
- R7: The control register sits at address 0xFE03. Bit 7 is the clear-enable bit, is read/write, and resets to 0 on every system reset. Bits 6 to 0 read 0.
- R8: Writes to the status address (default 0xFE01) have no effect on the flags.
- R9: `bus_rdata` is 0 when no read strobe is active, and also when a read targets an unmapped address. Such a read does not clear the flags.
- R10: Changes on the cause inputs after reset release have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| rc_por | input | 1 | Power-on reset cause |
| rc_pin | input | 1 | External reset pin cause |
| rc_wdog | input | 1 | Watchdog timeout cause |
| rc_badop | input | 1 | Illegal opcode cause |
| rc_badaddr | input | 1 | Illegal opcode-fetch address cause |
| rc_monitor | input | 1 | Monitor-mode entry cause |
| rc_lowv | input | 1 | Low-voltage inhibit cause |
| dbg_break | input | 1 | Debug break state active |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the status byte at 0xFE01 and the control byte at 0xFE03. These defaults make it possible to reach the following cases:
- every single cause on its own;
- power-on mixed with other causes;
- mixed non-power-on causes;
- a write to the status address;
- a read at an address that matches neither register.

Debug break is exercised with the clear-enable bit both low and high, and the bench repeats reads to show that the flags are kept or cleared.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int RC_NUM   = 7;
  localparam int RC_W     = RC_NUM + 1;
  localparam int POR_IDX  = RC_NUM - 1;   // index in the cause vector
  localparam int POR_BIT  = POR_IDX + 1;  // bit in the status byte
  localparam int CLR_EN_BIT = 7;
  localparam logic [RC_W-1:0] POR_MASK = RC_W'(1) << POR_BIT;
endpackage

// File: rtl/rcs_capture.sv
module rcs_capture
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RC_NUM-1:0] cause_i,
  input  logic              clr_i,
  output logic [RC_W-1:0]   flags_o,
  output logic              armed_o
);
  logic              armed_q;
  logic [RC_W-1:0]   flags_q;
  logic [RC_W-1:0]   next_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign next_flags[0] = 1'b0;
  for (genvar i = 0; i < RC_NUM; i++) begin : g_map
    if (i == POR_IDX) begin : g_por
      assign next_flags[i+1] = cause_i[i];
    end else begin : g_other
      assign next_flags[i+1] = cause_i[i] & ~cause_i[POR_IDX];
    end
  end

  // loaded while reset holds armed_q low, last load on the release edge
  always_ff @(posedge clk) begin
    if (!armed_q)   flags_q <= next_flags;
    else if (clr_i) flags_q <= '0;
  end

  assign flags_o = flags_q;
  assign armed_o = armed_q;

  assert_por_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && flags_q[POR_BIT]) |-> ((flags_q & ~POR_MASK) == '0));
  assert_rdclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && clr_i) |=> (flags_q == '0));
  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !clr_i) |=> $stable(flags_q));
endmodule

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wbit_i,
  output logic clr_en_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= 1'b0;
    else if (wr_i) en_q <= wbit_i;
  end

  assign clr_en_o = en_q;

  assert_ctrl_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_q == $past(wbit_i)));
  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_q));
endmodule

// File: rtl/rcs_bus.sv
module rcs_bus
  import rcs_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE01,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'hFE03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              brk_i,
  input  logic              clr_en_i,
  input  logic [RC_W-1:0]   flags_i,
  output logic              ctrl_wr_o,
  output logic              clr_o,
  output logic [RC_W-1:0]   rdata_o
);
  logic hit_stat, hit_ctrl;

  assign hit_stat  = (addr_i == STATUS_ADDR);
  assign hit_ctrl  = (addr_i == CTRL_ADDR);
  assign ctrl_wr_o = wr_i & hit_ctrl;
  assign clr_o     = rd_i & hit_stat & (~brk_i | clr_en_i);

  always_comb begin
    rdata_o = '0;
    if (rd_i && hit_stat)      rdata_o = flags_i;
    else if (rd_i && hit_ctrl) rdata_o[CLR_EN_BIT] = clr_en_i;
  end

  assert_brk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && hit_stat && brk_i && !clr_en_i) |-> !clr_o);
  assert_brk_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && hit_stat && brk_i && clr_en_i) |-> clr_o);
  assert_ctrl_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && hit_ctrl) |-> (rdata_o[CLR_EN_BIT-1:0] == '0));
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i || (!hit_stat && !hit_ctrl)) |-> (rdata_o == '0 && !clr_o));
endmodule

// File: rtl/reset_cause_status.sv
module reset_cause_status
  import rcs_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE01,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'hFE03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rc_por,
  input  logic              rc_pin,
  input  logic              rc_wdog,
  input  logic              rc_badop,
  input  logic              rc_badaddr,
  input  logic              rc_monitor,
  input  logic              rc_lowv,
  input  logic              dbg_break,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [RC_W-1:0]   bus_wdata,
  output logic [RC_W-1:0]   bus_rdata
);
  logic [RC_NUM-1:0] cause_vec;
  logic [RC_W-1:0]   flags;
  logic              armed;
  logic              clr;
  logic              clr_en;
  logic              ctrl_wr;
  logic              wdata_unused;

  assign cause_vec = {rc_por, rc_pin, rc_wdog, rc_badop,
                      rc_badaddr, rc_monitor, rc_lowv};
  assign wdata_unused = ^{bus_wdata[CLR_EN_BIT-1:0], armed};

  rcs_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cause_i(cause_vec), .clr_i(clr),
    .flags_o(flags), .armed_o(armed)
  );

  rcs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr),
    .wbit_i(bus_wdata[CLR_EN_BIT]), .clr_en_o(clr_en)
  );

  rcs_bus #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .rd_i(bus_rd), .wr_i(bus_wr), .addr_i(bus_addr),
    .brk_i(dbg_break), .clr_en_i(clr_en), .flags_i(flags),
    .ctrl_wr_o(ctrl_wr), .clr_o(clr), .rdata_o(bus_rdata)
  );

  assert_wr_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_wr && !bus_rd && bus_addr == STATUS_ADDR) |=> $stable(flags));
endmodule

// File: tb/test_reset_cause_status.sv
`timescale 1ns/1ps
module test_reset_cause_status;
  localparam logic [15:0] A_STAT = 16'hFE01;
  localparam logic [15:0] A_CTRL = 16'hFE03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] c = 7'd0;
  logic dbg_break = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  reset_cause_status i_reset_cause_status (
    .clk(clk), .rst_n(rst_n),
    .rc_por(c[6]), .rc_pin(c[5]), .rc_wdog(c[4]), .rc_badop(c[3]),
    .rc_badaddr(c[2]), .rc_monitor(c[1]), .rc_lowv(c[0]),
    .dbg_break(dbg_break), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] exp_of(input logic [6:0] v);
    return v[6] ? 8'h80 : {1'b0, v[5:0], 1'b0};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [6:0] v);
    @(negedge clk);
    rst_n = 1'b0; c = v; dbg_break = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    c = 7'd0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic t_power_on;
    logic [7:0] d;
    do_reset(7'b1000000);
    check("R9 idle rdata", bus_rdata, 8'h00);
    rd(A_CTRL, d); check("R7 ctrl after reset", d, 8'h00);
    rd(A_STAT, d); check("R1 por only", d, exp_of(7'b1000000));
    rd(A_STAT, d); check("R4 cleared after read", d, 8'h00);
    do_reset(7'b1110001);
    rd(A_STAT, d); check("R1 por with others", d, 8'h80);
  endtask

  task automatic t_single_and_mixed;
    logic [7:0] d;
    for (int i = 0; i < 6; i++) begin
      do_reset(7'(1 << i));
      rd(A_STAT, d); check("R2 single cause", d, 8'(1 << (i + 1)));
    end
    do_reset(7'b0100000);
    do_reset(7'b0010001);
    rd(A_STAT, d); check("R3 mixed causes, R2 replaced", d, 8'h22);
  endtask

  task automatic t_break_hold;
    logic [7:0] d;
    do_reset(7'b0001000);
    dbg_break = 1'b1;
    rd(A_STAT, d); check("R5 break read", d, 8'h10);
    rd(A_STAT, d); check("R5 break kept", d, 8'h10);
    dbg_break = 1'b0;
    rd(A_STAT, d); check("R4 read after break", d, 8'h10);
    rd(A_STAT, d); check("R4 cleared", d, 8'h00);
  endtask

  task automatic t_break_clear;
    logic [7:0] d;
    do_reset(7'b0000001);
    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, d); check("R7 ctrl bit7 only", d, 8'h80);
    wr(A_CTRL, 8'h7F);
    rd(A_CTRL, d); check("R7 ctrl write zero", d, 8'h00);
    wr(A_CTRL, 8'h80);
    do_reset(7'b0000010);
    rd(A_CTRL, d); check("R7 ctrl reset to 0", d, 8'h00);
    wr(A_CTRL, 8'h80);
    dbg_break = 1'b1;
    rd(A_STAT, d); check("R6 break read", d, 8'h04);
    rd(A_STAT, d); check("R6 break cleared", d, 8'h00);
    dbg_break = 1'b0;
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    do_reset(7'b0000100);
    wr(A_STAT, 8'h00);
    wr(A_STAT, 8'hFF);
    rd(16'h1234, d); check("R9 unmapped read", d, 8'h00);
    @(negedge clk); c = 7'b1111111;
    @(negedge clk); c = 7'b0000000;
    rd(A_STAT, d); check("R8 R9 R10 flags intact", d, 8'h08);
  endtask

  initial begin
    t_power_on();
    t_single_and_mixed();
    t_break_hold();
    t_break_clear();
    t_ignored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule